// File: doc/BRIEF.md
# Direction-Switchable Shared Data FIFO

One storage array carries data for both transfer directions of a storage interface. A mode bit chooses the direction. In transmit mode the host-side port writes and the device-side port reads. In receive mode the device-side port writes and the host-side port reads. Strobes from the side that does not hold a role in the current mode are ignored.

The array holds 512 bytes. It is made of four byte-wide banks of 128 entries, so each entry is one 32-bit word. A word is split across the four banks, and byte enables select which banks take a write. The read side works first-word-fall-through: the oldest word is on the reader's data output while the FIFO is not empty, and a read strobe removes it.

Software must flush the FIFO before it turns the direction around. A direction request that arrives while data is still stored is refused, and a sticky error is raised. Sticky overflow and underflow flags record requests that were dropped. A level output gives the number of stored words.

Top module: `dual_dir_fifo`

## Requirements
- R1: After reset the block is in receive mode (`mode_tx_o`=0). It shows `empty_o`=1, `full_o`=0 and `level_o`=0, and all three sticky flags read 0.
- R2: Transmit mode (`mode_tx_o`=1): host writes go in and the device port reads them out in write order. Receive mode (`mode_tx_o`=0): device writes go in and the host port reads them out in write order.
- R3: Write and read strobes from the port that has no role in the current mode have no effect. The read data output of the port that is not reading is 0.
- R4: Byte enable bit k (k=0 is bits 7:0) writes byte k of the word into bank k. A bank whose enable is low keeps its old byte. A flush does not clear the banks.
- R5: `level_o` counts the stored words from 0 to 128. `full_o` is high exactly at 128 and `empty_o` is high exactly at 0.
- R6: A write while full is dropped and sets the sticky `ovf_o`. A read in the same cycle still removes one word.
- R7: A read while empty is dropped and sets the sticky `udf_o`. A write in the same cycle is still stored.
- R8: A flush sets the level and both pointers to 0 in one cycle and clears all sticky flags. Port strobes in the flush cycle are dropped.
- R9: A direction request (`mode_req_i` with the new value on `mode_tx_i`) takes effect on the next cycle if the FIFO is empty or if a flush is given in the same cycle. Otherwise the direction is kept and the sticky `dir_err_o` is set.
- R10: In a cycle with a direction request, port write and read strobes have no effect.
- R11: While the FIFO is empty, the read data output of the reading port is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the FIFO and clear the sticky flags |
| mode_req_i | input | 1 | Direction change request |
| mode_tx_i | input | 1 | Requested direction: 1 transmit, 0 receive |
| host_wr_i | input | 1 | Host write strobe |
| host_be_i | input | 4 | Host byte enables |
| host_wdata_i | input | 32 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 32 | Head word while host reads, else 0 |
| dev_wr_i | input | 1 | Device write strobe |
| dev_be_i | input | 4 | Device byte enables |
| dev_wdata_i | input | 32 | Device write data |
| dev_rd_i | input | 1 | Device read strobe |
| dev_rdata_o | output | 32 | Head word while device reads, else 0 |
| mode_tx_o | output | 1 | Current direction, 1 transmit |
| full_o | output | 1 | 128 words stored |
| empty_o | output | 1 | No words stored |
| level_o | output | 8 | Stored word count |
| ovf_o | output | 1 | Sticky dropped-write flag |
| udf_o | output | 1 | Sticky dropped-read flag |
| dir_err_o | output | 1 | Sticky refused-direction flag |

## Verification
Four pairs of functions can meet in one cycle, and each pair is driven together on purpose:
- A write and a read on a full FIFO: the level falls by one, `ovf_o` rises, and the head moves to the second word.
- A read and a write on an empty FIFO: the level becomes one, `udf_o` rises, and the new word is the head.
- A flush with a port write: the FIFO ends empty.
- A flush with a direction request: the new direction is taken and the error flag stays clear.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/dfifo_bank.sv
module dfifo_bank #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dfifo_port_mux.sv
module dfifo_port_mux import dfifo_pkg::*; #(
  parameter int NB = 4,
  localparam int DW = NB * 8
) (
  input  dir_e          mode_i,
  input  logic          empty_i,
  input  logic [DW-1:0] head_i,
  input  logic          host_wr_i,
  input  logic [NB-1:0] host_be_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          dev_wr_i,
  input  logic [NB-1:0] dev_be_i,
  input  logic [DW-1:0] dev_wdata_i,
  input  logic          dev_rd_i,
  output logic [DW-1:0] dev_rdata_o,
  output logic          wr_req_o,
  output logic [NB-1:0] wr_be_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_req_o
);
  logic [DW-1:0] head_vis;
  assign head_vis = empty_i ? '0 : head_i;

  always_comb begin
    if (mode_i == DIR_TX) begin
      wr_req_o     = host_wr_i;
      wr_be_o      = host_be_i;
      wr_data_o    = host_wdata_i;
      rd_req_o     = dev_rd_i;
      dev_rdata_o  = head_vis;
      host_rdata_o = '0;
    end else begin
      wr_req_o     = dev_wr_i;
      wr_be_o      = dev_be_i;
      wr_data_o    = dev_wdata_i;
      rd_req_o     = host_rd_i;
      host_rdata_o = head_vis;
      dev_rdata_o  = '0;
    end
  end
endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl import dfifo_pkg::*; #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          mode_req_i,
  input  logic          mode_tx_i,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          push_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output dir_e          mode_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic          dir_err_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  dir_e          mode_q;
  logic          ovf_q, udf_q, err_q;
  logic          gate, push, pop, drop_wr, drop_rd, mode_ok, mode_bad;

  assign full_o  = (level_q == FULL_LVL);
  assign empty_o = (level_q == '0);

  // flush and direction requests both freeze the ports for the cycle
  assign gate     = ~flush_i & ~mode_req_i;
  assign push     = gate & wr_req_i & ~full_o;
  assign pop      = gate & rd_req_i & ~empty_o;
  assign drop_wr  = gate & wr_req_i & full_o;
  assign drop_rd  = gate & rd_req_i & empty_o;
  assign mode_ok  = mode_req_i & (empty_o | flush_i);
  assign mode_bad = mode_req_i & ~empty_o & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DIR_RX;
    end else if (mode_ok) begin
      mode_q <= mode_tx_i ? DIR_TX : DIR_RX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      err_q <= 1'b0;
    end else if (flush_i) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (drop_wr)  ovf_q <= 1'b1;
      if (drop_rd)  udf_q <= 1'b1;
      if (mode_bad) err_q <= 1'b1;
    end
  end

  assign push_o    = push;
  assign wr_ptr_o  = wr_ptr_q;
  assign rd_ptr_o  = rd_ptr_q;
  assign mode_o    = mode_q;
  assign level_o   = level_q;
  assign ovf_o     = ovf_q;
  assign udf_o     = udf_q;
  assign dir_err_o = err_q;

  assert_level_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= FULL_LVL);

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0) && (wr_ptr_q == '0) && (rd_ptr_q == '0) && !ovf_q && !udf_q && !err_q);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_req_i && !flush_i && !mode_req_i) |=> full_o);

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_req_i && !flush_i && !mode_req_i) |=> empty_o);

  assert_dir_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && !empty_o && !flush_i) |=> ($stable(mode_q) && err_q));

  assert_mode_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && !flush_i) |=> $stable(level_q));
endmodule

// File: rtl/dual_dir_fifo.sv
module dual_dir_fifo import dfifo_pkg::*; #(
  parameter int NB    = 4,
  parameter int DEPTH = 128,
  localparam int DW = NB * 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          mode_req_i,
  input  logic          mode_tx_i,
  input  logic          host_wr_i,
  input  logic [NB-1:0] host_be_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          dev_wr_i,
  input  logic [NB-1:0] dev_be_i,
  input  logic [DW-1:0] dev_wdata_i,
  input  logic          dev_rd_i,
  output logic [DW-1:0] dev_rdata_o,
  output logic          mode_tx_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic          dir_err_o
);
  dir_e          mode;
  logic          wr_req, rd_req, push;
  logic [NB-1:0] wr_be;
  logic [DW-1:0] wr_data, head;
  logic [AW-1:0] wr_ptr, rd_ptr;

  dfifo_port_mux #(.NB(NB)) i_mux (
    .mode_i       (mode),
    .empty_i      (empty_o),
    .head_i       (head),
    .host_wr_i    (host_wr_i),
    .host_be_i    (host_be_i),
    .host_wdata_i (host_wdata_i),
    .host_rd_i    (host_rd_i),
    .host_rdata_o (host_rdata_o),
    .dev_wr_i     (dev_wr_i),
    .dev_be_i     (dev_be_i),
    .dev_wdata_i  (dev_wdata_i),
    .dev_rd_i     (dev_rd_i),
    .dev_rdata_o  (dev_rdata_o),
    .wr_req_o     (wr_req),
    .wr_be_o      (wr_be),
    .wr_data_o    (wr_data),
    .rd_req_o     (rd_req)
  );

  dfifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .mode_req_i (mode_req_i),
    .mode_tx_i  (mode_tx_i),
    .wr_req_i   (wr_req),
    .rd_req_i   (rd_req),
    .push_o     (push),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .mode_o     (mode),
    .level_o    (level_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .ovf_o      (ovf_o),
    .udf_o      (udf_o),
    .dir_err_o  (dir_err_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    dfifo_bank #(.DEPTH(DEPTH)) i_bank (
      .clk_i   (clk_i),
      .we_i    (push & wr_be[b]),
      .waddr_i (wr_ptr),
      .wdata_i (wr_data[b*8 +: 8]),
      .raddr_i (rd_ptr),
      .rdata_o (head[b*8 +: 8])
    );
  end

  assign mode_tx_o = (mode == DIR_TX);

  assert_idle_port_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_tx_o ? (host_rdata_o == '0) : (dev_rdata_o == '0));

  assert_empty_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (host_rdata_o == '0) && (dev_rdata_o == '0));
endmodule

// File: tb/test_dual_dir_fifo.sv
module test_dual_dir_fifo;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, mode_req_i = 1'b0, mode_tx_i = 1'b0;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0, dev_wr_i = 1'b0, dev_rd_i = 1'b0;
  logic [3:0]  host_be_i = 4'hf, dev_be_i = 4'hf;
  logic [31:0] host_wdata_i = '0, dev_wdata_i = '0;
  logic [31:0] host_rdata_o, dev_rdata_o;
  logic        mode_tx_o, full_o, empty_o, ovf_o, udf_o, dir_err_o;
  logic [7:0]  level_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  dual_dir_fifo i_dual_dir_fifo (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    flush_i = 0; mode_req_i = 0; host_wr_i = 0; host_rd_i = 0;
    dev_wr_i = 0; dev_rd_i = 0; host_be_i = 4'hf; dev_be_i = 4'hf;
  endtask

  task automatic set_mode(logic tx);
    mode_req_i = 1; mode_tx_i = tx; cyc(); idle();
  endtask

  task automatic do_flush();
    flush_i = 1; cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 level", 32'(level_o), 0);
    chk("R1 mode", 32'(mode_tx_o), 0);
    chk("R1 flags", {29'b0, ovf_o, udf_o, dir_err_o}, 0);
  endtask

  task automatic t_tx_path();
    set_mode(1);
    chk("R9 mode tx", 32'(mode_tx_o), 1);
    for (int i = 0; i < 3; i++) begin
      host_wr_i = 1; host_wdata_i = 32'hA000_0000 + i; cyc();
    end
    idle();
    chk("R5 level 3", 32'(level_o), 3);
    chk("R2 tx head", dev_rdata_o, 32'hA000_0000);
    chk("R3 host rdata zero", host_rdata_o, 0);
    dev_rd_i = 1; cyc(); idle();
    chk("R2 tx order", dev_rdata_o, 32'hA000_0001);
    chk("R5 level 2", 32'(level_o), 2);
    dev_rd_i = 1; cyc(); cyc(); idle();
    chk("R5 empty", 32'(empty_o), 1);
    chk("R11 rdata zero empty", dev_rdata_o, 0);
  endtask

  task automatic t_wrong_side();
    dev_wr_i = 1; dev_wdata_i = 32'h5555_5555; cyc(); idle();
    chk("R3 dev write ignored in tx", 32'(level_o), 0);
    host_wr_i = 1; host_wdata_i = 32'h0000_00AB; cyc(); idle();
    host_rd_i = 1; cyc(); idle();
    chk("R3 host read ignored in tx", 32'(level_o), 1);
    chk("R3 head kept", dev_rdata_o, 32'h0000_00AB);
    do_flush();
  endtask

  task automatic t_rx_path();
    set_mode(0);
    chk("R9 mode rx", 32'(mode_tx_o), 0);
    dev_wr_i = 1; dev_wdata_i = 32'h1111_0001; cyc();
    dev_wdata_i = 32'h1111_0002; cyc(); idle();
    chk("R2 rx head", host_rdata_o, 32'h1111_0001);
    chk("R3 dev rdata zero", dev_rdata_o, 0);
    host_rd_i = 1; cyc(); idle();
    chk("R2 rx order", host_rdata_o, 32'h1111_0002);
    do_flush();
  endtask

  task automatic t_byte_enables();
    dev_wr_i = 1; dev_wdata_i = 32'hAABB_CCDD; cyc(); idle();
    do_flush();
    dev_wr_i = 1; dev_be_i = 4'b0011; dev_wdata_i = 32'h1122_3344; cyc(); idle();
    chk("R4 partial write", host_rdata_o, 32'hAABB_3344);
    do_flush();
  endtask

  task automatic t_full_overflow();
    for (int i = 0; i < 128; i++) begin
      dev_wr_i = 1; dev_wdata_i = 32'h100 + i; cyc();
    end
    idle();
    chk("R5 full", 32'(full_o), 1);
    chk("R5 level 128", 32'(level_o), 128);
    dev_wr_i = 1; dev_wdata_i = 32'hDEAD; host_rd_i = 1; cyc(); idle();
    chk("R6 level after read", 32'(level_o), 127);
    chk("R6 ovf set", 32'(ovf_o), 1);
    chk("R6 head advanced", host_rdata_o, 32'h101);
    host_rd_i = 1;
    for (int i = 0; i < 126; i++) cyc();
    idle();
    chk("R6 last word", host_rdata_o, 32'h17F);
    host_rd_i = 1; cyc(); idle();
    chk("R5 empty after drain", 32'(empty_o), 1);
    chk("R6 ovf sticky", 32'(ovf_o), 1);
  endtask

  task automatic t_underflow();
    host_rd_i = 1; dev_wr_i = 1; dev_wdata_i = 32'hBEEF; cyc(); idle();
    chk("R7 level 1", 32'(level_o), 1);
    chk("R7 udf set", 32'(udf_o), 1);
    chk("R7 head", host_rdata_o, 32'hBEEF);
    do_flush();
    chk("R8 level 0", 32'(level_o), 0);
    chk("R8 flags cleared", {30'b0, ovf_o, udf_o}, 0);
  endtask

  task automatic t_flush_with_write();
    dev_wr_i = 1; dev_wdata_i = 32'h7; cyc(); cyc();
    flush_i = 1; cyc(); idle();
    chk("R8 flush beats write", 32'(level_o), 0);
    chk("R8 empty", 32'(empty_o), 1);
  endtask

  task automatic t_mode_refused();
    dev_wr_i = 1; dev_wdata_i = 32'h9; cyc(); idle();
    set_mode(1);
    chk("R9 refused keeps rx", 32'(mode_tx_o), 0);
    chk("R9 dir_err set", 32'(dir_err_o), 1);
    chk("R9 data kept", 32'(level_o), 1);
    flush_i = 1; mode_req_i = 1; mode_tx_i = 1; cyc(); idle();
    chk("R9 flush with request", 32'(mode_tx_o), 1);
    chk("R8 dir_err cleared", 32'(dir_err_o), 0);
  endtask

  task automatic t_mode_freeze();
    mode_req_i = 1; mode_tx_i = 1; host_wr_i = 1; host_wdata_i = 32'h42; cyc(); idle();
    chk("R10 write frozen", 32'(level_o), 0);
    host_wr_i = 1; cyc(); idle();
    mode_req_i = 1; mode_tx_i = 1; dev_rd_i = 1; cyc(); idle();
    chk("R10 read frozen", 32'(level_o), 1);
  endtask

  initial begin
    fork
      begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    cyc();
    t_reset();
    t_tx_path();
    t_wrong_side();
    t_rx_path();
    t_byte_enables();
    t_full_overflow();
    t_underflow();
    t_flush_with_write();
    t_mode_refused();
    t_mode_freeze();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule